// File: doc/BRIEF.md
# Iterative 64-bit Integer Multiplier

This block computes the integer products needed by a 64-bit processor's multiply instructions. A caller presents two 64-bit operands, a 3-bit function code and a word-form flag. The unit returns one 64-bit result. That result is one of the following:

- the low half of the 128-bit product;
- the high half, with both operands read as signed;
- the high half, with the first operand signed and the second unsigned;
- the high half, with both operands unsigned;
- the 32-bit word form, whose product is sign-extended to 64 bits.

Internally the unit first takes the magnitudes of the operands. It then adds four 32x32 partial products into a 128-bit accumulator, one partial product per cycle. In the final cycle it negates the whole product when the operand signs differ, and selects the requested half.

Operands enter through a valid/ready handshake and are accepted only while the unit is idle. The result comes back as a single-cycle pulse on `out_valid`. That pulse appears five clock edges after the accepting edge. The unit is ready again in the same cycle as the pulse, so operations can follow each other with no gap.

Top module: `rv_mul_unit`

## Requirements
- R1: With `in_word`=0 and `in_op[1:0]`=0, the result is bits 63:0 of the product of `in_a` and `in_b`.
- R2: With `in_word`=0 and `in_op[1:0]`=1, the result is bits 127:64 of the product, with both operands read as two's-complement signed.
- R3: With `in_word`=0 and `in_op[1:0]`=2, the result is bits 127:64 of the product, with `in_a` read as signed and `in_b` read as unsigned.
- R4: With `in_word`=0 and `in_op[1:0]`=3, the result is bits 127:64 of the product, with both operands read as unsigned.
- R5: With `in_word`=1, the result is bit 31 of the product `in_a[31:0]*in_b[31:0]` repeated 32 times, followed by bits 31:0 of that product. In this mode `in_op` has no effect.
- R6: `in_op[2]` has no effect, so function codes 4 to 7 give the same results as codes 0 to 3.
- R7: `in_ready` is high only while the unit is idle. A request made while `in_ready` is low is not accepted and does not change the result of the operation in progress.
- R8: `out_valid` is high for exactly one cycle per accepted operation. It rises on the fifth rising edge after the edge that accepted the operation, and `out_result` is valid while `out_valid` is high.
- R9: `in_ready` is high in every cycle in which `out_valid` is high, so the next operation can be accepted in the cycle its predecessor delivers.
- R10: While `rst_n` is low, and after it is released, `in_ready` is 1 and `out_valid` is 0 until an operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle; a request is taken at this edge |
| in_op | input | 3 | Function code; bits 1:0 select low half or high-half signedness |
| in_word | input | 1 | Selects the 32-bit word form with sign-extended result |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Single-cycle result strobe |
| out_result | output | 64 | Result value |

## Verification
Two events share a cycle under back-to-back traffic: the result of one operation is delivered, and the next request is accepted. The driver holds `in_valid` high continuously and presents the next request as soon as `in_ready` is seen. It also swaps in scrambled operands and codes during the busy cycles. The monitor then checks three things for every pulse: the delivered value against a 128-bit reference product, the pulse's edge count from its own acceptance, and that `in_ready` is high in the same cycle. A result that was corrupted by the overlapping acceptance, or by the scrambled busy-time inputs, would fail these checks.

// File: rtl/mulu_pkg.sv
package mulu_pkg;

  typedef enum logic [1:0] {
    SEL_LO  = 2'd0,
    SEL_HSS = 2'd1,
    SEL_HSU = 2'd2,
    SEL_HUU = 2'd3
  } mul_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } eng_state_e;

endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep
  import mulu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  mul_sel_e        sel,
  input  logic            word,
  output logic [XLEN-1:0] mag_a,
  output logic [XLEN-1:0] mag_b,
  output logic            negate
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] a_src, b_src;
  logic a_signed, b_signed, a_neg, b_neg;

  always_comb begin
    // Word form: only the low halves take part, read as unsigned.
    a_src    = word ? {{HALF{1'b0}}, op_a[HALF-1:0]} : op_a;
    b_src    = word ? {{HALF{1'b0}}, op_b[HALF-1:0]} : op_b;
    a_signed = !word && ((sel == SEL_HSS) || (sel == SEL_HSU));
    b_signed = !word && (sel == SEL_HSS);
    a_neg    = a_signed && a_src[XLEN-1];
    b_neg    = b_signed && b_src[XLEN-1];
    mag_a    = a_neg ? (~a_src + 1'b1) : a_src;
    mag_b    = b_neg ? (~b_src + 1'b1) : b_src;
    negate   = a_neg ^ b_neg;
  end

endmodule

// File: rtl/mul_pp_engine.sv
module mul_pp_engine
  import mulu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [XLEN-1:0]   mag_a,
  input  logic [XLEN-1:0]   mag_b,
  output logic              busy,
  output logic              fin,
  output logic [2*XLEN-1:0] product
);
  localparam int LIMB = XLEN / 2;
  localparam int PW   = 2 * XLEN;

  eng_state_e      state_q, state_d;
  logic [1:0]      step_q, step_d;
  logic [XLEN-1:0] a_q, b_q;
  logic [PW-1:0]   acc_q, acc_d;
  logic            ld_en, acc_en;

  logic [LIMB-1:0] a_limb, b_limb;
  logic [XLEN-1:0] pp;
  logic [PW-1:0]   pp_ext, pp_sh;

  // Partial product for this step: step[1] picks the a limb, step[0] the b limb.
  always_comb begin
    a_limb = step_q[1] ? a_q[XLEN-1:LIMB] : a_q[LIMB-1:0];
    b_limb = step_q[0] ? b_q[XLEN-1:LIMB] : b_q[LIMB-1:0];
    pp     = XLEN'(a_limb) * XLEN'(b_limb);
    pp_ext = {{XLEN{1'b0}}, pp};
    case (step_q)
      2'd0:    pp_sh = pp_ext;
      2'd3:    pp_sh = pp_ext << XLEN;
      default: pp_sh = pp_ext << LIMB;
    endcase
  end

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    ld_en   = 1'b0;
    acc_en  = 1'b0;
    acc_d   = acc_q + pp_sh;
    case (state_q)
      ST_IDLE: if (start) begin
        ld_en   = 1'b1;
        step_d  = 2'd0;
        state_d = ST_RUN;
      end
      ST_RUN: begin
        acc_en = 1'b1;
        step_d = step_q + 2'd1;
        if (step_q == 2'd3) state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= 2'd0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      a_q <= mag_a;
      b_q <= mag_b;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en)       acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign busy    = (state_q != ST_IDLE);
  assign fin     = (state_q == ST_FIN);
  assign product = acc_q;

  // R7: the top only starts the engine while it is idle
  a_r7_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (state_q == ST_IDLE));

  // R8: the finish state is entered only after the fourth accumulation step
  a_r8_four_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) && (step_q == 2'd3) |=> (state_q == ST_FIN));

  a_r8_fin_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN) |-> $past(state_q == ST_RUN));

endmodule

// File: rtl/mul_result_fmt.sv
module mul_result_fmt
  import mulu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2*XLEN-1:0] product,
  input  logic              negate,
  input  mul_sel_e          sel,
  input  logic              word,
  output logic [XLEN-1:0]   result
);
  localparam int HALF = XLEN / 2;

  logic [2*XLEN-1:0] sprod;

  always_comb begin
    // Negate the full-width product so a zero low half carries into the high half.
    sprod = negate ? (~product + 1'b1) : product;
    if (word)               result = {{HALF{sprod[HALF-1]}}, sprod[HALF-1:0]};
    else if (sel == SEL_LO) result = sprod[XLEN-1:0];
    else                    result = sprod[2*XLEN-1:XLEN];
  end

endmodule

// File: rtl/rv_mul_unit.sv
module rv_mul_unit
  import mulu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_op,
  input  logic            in_word,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result
);
  localparam int HALF = XLEN / 2;

  mul_sel_e          sel_in, sel_q;
  logic              word_q, neg_q, neg_in;
  logic              accept, busy, fin;
  logic [XLEN-1:0]   mag_a, mag_b, fmt_res, res_q;
  logic [2*XLEN-1:0] product;
  logic              ov_q;
  logic              op_hi_unused;

  assign op_hi_unused = in_op[2];   // upper function bit plays no part
  assign sel_in   = mul_sel_e'(in_op[1:0]);
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  mul_operand_prep #(.XLEN(XLEN)) u_prep (
    .op_a(in_a), .op_b(in_b), .sel(sel_in), .word(in_word),
    .mag_a(mag_a), .mag_b(mag_b), .negate(neg_in)
  );

  mul_pp_engine #(.XLEN(XLEN)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .mag_a(mag_a), .mag_b(mag_b),
    .busy(busy), .fin(fin), .product(product)
  );

  mul_result_fmt #(.XLEN(XLEN)) u_fmt (
    .product(product), .negate(neg_q), .sel(sel_q), .word(word_q),
    .result(fmt_res)
  );

  always_ff @(posedge clk) begin
    if (accept) begin
      sel_q  <= sel_in;
      word_q <= in_word;
      neg_q  <= neg_in;
    end
  end

  always_ff @(posedge clk) begin
    if (fin) res_q <= fmt_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_q <= 1'b0;
    else        ov_q <= fin;
  end

  assign out_valid  = ov_q;
  assign out_result = res_q;

  // R8: result strobe lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R9: ready coincides with every result
  a_r9_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  // R7: acceptance makes the unit busy on the next cycle
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R5: word results are sign-extended from bit HALF-1
  a_r5_word_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && word_q) |-> (out_result[XLEN-1:HALF] == {HALF{out_result[HALF-1]}}));

endmodule

// File: tb/sim_rv_mul_unit.sv
module sim_rv_mul_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_word, out_valid;
  logic [2:0]  in_op;
  logic [63:0] in_a, in_b, out_result;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  bit prev_ov = 0;

  logic [63:0] exp_q[$];
  int          acc_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rv_mul_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_word(in_word), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_result(out_result)
  );

  function automatic logic [63:0] ref_mul(logic [2:0] op, logic word,
                                          logic [63:0] a, logic [63:0] b);
    logic [127:0] ax, bx, p;
    logic [63:0]  w;
    if (word) begin
      w = {32'b0, a[31:0]} * {32'b0, b[31:0]};
      return {{32{w[31]}}, w[31:0]};
    end
    case (op[1:0])
      2'd0: begin w = a * b; return w; end
      2'd1: begin ax = {{64{a[63]}}, a}; bx = {{64{b[63]}}, b}; end
      2'd2: begin ax = {{64{a[63]}}, a}; bx = {64'b0, b}; end
      default: begin ax = {64'b0, a}; bx = {64'b0, b}; end
    endcase
    p = ax * bx;
    return p[127:64];
  endfunction

  function automatic string tag_of(logic [2:0] op, logic word);
    if (word)   return "R5";
    if (op[2])  return "R6";
    case (op[1:0])
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: waits for ready, records expectation, then scrambles inputs while busy (R7).
  task automatic issue(logic [2:0] op, logic word, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_word = word; in_a = a; in_b = b;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(ref_mul(op, word, a, b));
    acc_q.push_back(cyc + 1);
    tag_q.push_back(tag_of(op, word));
    @(posedge clk);
    #1;
    in_a = ~a; in_b = b ^ 64'h5A5A_5A5A_5A5A_5A5A;
    in_op = op + 3'd1; in_word = ~word;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R8", 64'd1, 64'd0);
        end else begin
          automatic logic [63:0] e = exp_q.pop_front();
          automatic int          t = acc_q.pop_front();
          automatic string       g = tag_q.pop_front();
          check(g, out_result, e);
          check("R8", 64'(cyc), 64'(t + 5));
          check("R9", {63'b0, in_ready}, 64'd1);
        end
        if (prev_ov) check("R8", 64'd1, 64'd0);
      end
      prev_ov = out_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] corner [7];
    logic [63:0] lfsr;
    corner[0] = 64'h0;
    corner[1] = 64'h1;
    corner[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    corner[3] = 64'h8000_0000_0000_0000;
    corner[4] = 64'h7FFF_FFFF_FFFF_FFFF;
    corner[5] = 64'h0000_0000_FFFF_FFFF;
    corner[6] = 64'hDEAD_BEEF_1234_5678;
    in_valid = 0; in_op = 0; in_word = 0; in_a = 0; in_b = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R10", {62'b0, in_ready, out_valid}, 64'd2);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R10", {62'b0, in_ready, out_valid}, 64'd2);

    // R1..R4: all corner pairs, all four functions
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++)
          issue(3'(op), 1'b0, corner[i], corner[j]);
    // R5: word form, function code varied and ignored
    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 7; j++)
        issue(3'((i + j) % 8), 1'b1, corner[i], corner[j] ^ 64'h0000_0000_8000_0000);
    // R6: codes 4..7 alias 0..3
    for (int op = 4; op < 8; op++)
      for (int i = 0; i < 7; i++)
        issue(3'(op), 1'b0, corner[i], corner[6 - i]);
    // Gap in traffic, then pseudo-random mix
    @(negedge clk); in_valid = 0;
    repeat (8) @(negedge clk);
    check("R7", {63'b0, out_valid}, 64'd0);
    lfsr = 64'hACE1_2468_1357_9BDF;
    for (int k = 0; k < 80; k++) begin
      automatic logic [63:0] a = lfsr;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      lfsr = lfsr * 64'd6364136223846793005 + 64'd1442695040888963407;
      issue(3'(k % 8), (k % 5) == 0, a, lfsr);
    end
    @(negedge clk); in_valid = 0;
    for (int w = 0; w < 20 && exp_q.size() != 0; w++) @(negedge clk);
    check("R8", 64'(exp_q.size()), 64'd0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule